// File: doc/BRIEF.md
# Host Half-Word Swap Bridge

This block sits between a host data bus and a 32-bit internal data path of registers and FIFOs. The host bus is either a full 32-bit bus or a 16-bit bus, chosen by a static width input. On a 32-bit bus every access moves a whole word with byte 3 on the top lanes and byte 0 on the bottom lanes. On a 16-bit bus only the low sixteen lanes carry data, and the address line A1 picks which half of the internal word is moved.

A programmable half-swap register sets which value of A1 reaches the upper half of the word. If the register holds all ones, A1=0 reaches bytes 3:2. If it holds any other value, including its reset value of zero, A1=0 reaches bytes 1:0. Software can read the register back to see which order is in force.

For 16-bit writes, the half that carries bytes 3:2 is parked in a staging register. The half that carries bytes 1:0 completes the word, which goes to the target in one cycle. For 16-bit reads, the upper-half access captures the whole source word, so the lower-half access that follows returns data from that same word. Each cycle in which chip select and a strobe are both high counts as one access.

Top module: `host_word_bridge`

## Requirements
- R1: With `bus16`=0, a read (`hst_cs`=1, `hst_rd`=1) returns the source word on `hst_rdata` in the same cycle, unswapped. The source is the half-swap register when `hst_swap_sel`=1 and `tgt_rdata` otherwise.
- R2: `hst_rdata` is all zeros in any cycle where `hst_cs` and `hst_rd` are not both 1.
- R3: With `bus16`=1 and the half-swap register equal to all ones, an access with A1=0 targets bytes 3:2 (source bits 31:16) and an access with A1=1 targets bytes 1:0 (bits 15:0). The selected half appears on `hst_rdata[15:0]`.
- R4: With `bus16`=1 and the half-swap register at any other value, including all ones minus one, the selection in R3 is reversed: A1=1 targets bytes 3:2 and A1=0 targets bytes 1:0.
- R5: With `bus16`=1, `hst_rdata[31:16]` is zero on every read, and `hst_wdata[31:16]` has no effect on any stored or committed value.
- R6: A 16-bit read of bytes 1:0 that follows an upper-half read (no other lower-half read in between) returns bits 15:0 of the word captured at that upper-half read, whatever the live source holds now. A lower-half read with no pending capture returns the live source, and any lower-half read ends the capture.
- R7: With `bus16`=1, an upper-half write only stages its 16 bits and does not raise `tgt_we`. A lower-half write to the target raises `tgt_we` for one cycle after the access edge, with `tgt_wdata` = {last staged half, this half}.
- R8: With `bus16`=0, a target write raises `tgt_we` for one cycle after the access edge, with `tgt_wdata` equal to `hst_wdata`.
- R9: Writes with `hst_swap_sel`=1 update the half-swap register and never raise `tgt_we`. The register changes only on such writes and is read back through R1, R3 and R4. In 16-bit mode it is assembled from two halves as in R7, and the halves are chosen by the value it held before the write.
- R10: After reset, `tgt_we` is 0 and the half-swap register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus16 | input | 1 | 1 = 16-bit host bus, 0 = 32-bit; static after reset |
| hst_cs | input | 1 | Host chip select (already decoded) |
| hst_rd | input | 1 | Host read strobe |
| hst_wr | input | 1 | Host write strobe |
| hst_a1 | input | 1 | Host address bit A1, picks the half in 16-bit mode |
| hst_swap_sel | input | 1 | Access targets the half-swap register |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, zero when not reading |
| tgt_rdata | input | 32 | Read word from the internal data path |
| tgt_we | output | 1 | One-cycle write pulse to the internal data path |
| tgt_wdata | output | 32 | Assembled write word |

## Verification
Two cases can land in the same cycle. The first is a read together with the final half of a write to the half-swap register. The read must still pick its half using the register value from before the write, while the write changes the mode at the clock edge. The bench provokes this with random accesses that often raise both strobes and often select the swap register. A reference model works out the read with the old mode and the commit with the new one. The second case is a lower-half read served from the capture while the live source has already changed. Directed sequences feed different source words on consecutive half-reads, and the bench checks that the older word is returned.

// File: rtl/hwb_pkg.sv
// Shared types for the host half-word swap bridge.
// Assumes: the host bus width is fixed while out of reset.
package hwb_pkg;

    // Which part of the internal word a host access moves.
    typedef enum logic [1:0] {
        ACC_FULL = 2'd0,   // whole word on a 32-bit bus
        ACC_HI   = 2'd1,   // bytes 3:2 on a 16-bit bus
        ACC_LO   = 2'd2    // bytes 1:0 on a 16-bit bus
    } acc_kind_t;

    // Map bus width, A1 and swap mode to the part being accessed.
    function automatic acc_kind_t classify(input logic bus16,
                                           input logic a1,
                                           input logic all_ones_mode);
        if (!bus16)
            return ACC_FULL;
        return (a1 ^ all_ones_mode) ? ACC_HI : ACC_LO;
    endfunction

endpackage

// File: rtl/hwb_swap_reg.sv
// Half-swap control register.
// Holds the software-written swap word and flags when it is exactly all ones.
// Assumes: writes come as fully assembled words from the write assembler.
module hwb_swap_reg #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_word,
    output logic [DW-1:0] value,
    output logic          all_ones
);

    // Storage: clears to zero, loads on a committed write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (wr_en)
            value <= wr_word;
    end

    // Mode flag: only the exact all-ones pattern selects the swapped order.
    always_comb all_ones = &value;

endmodule

// File: rtl/hwb_wr_asm.sv
// Write assembler.
// Passes whole words through on a 32-bit bus. On a 16-bit bus it stages the
// upper half and builds the full word when the lower half arrives.
// Assumes: the kind input has already been derived from bus width, A1 and mode.
module hwb_wr_asm
    import hwb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  acc_kind_t     kind,
    input  logic [DW-1:0] wdata,
    output logic          commit,
    output logic [DW-1:0] word
);

    localparam int HW = DW / 2;

    logic [HW-1:0] stage_q;

    // Staging: capture the upper half on an upper-half write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q <= '0;
        else if (wr_en && kind == ACC_HI)
            stage_q <= wdata[HW-1:0];
    end

    // Commit: a full access or the closing lower half produces a word.
    always_comb begin
        commit = wr_en && (kind != ACC_HI);
        word   = (kind == ACC_FULL) ? wdata : {stage_q, wdata[HW-1:0]};
    end

    // R7: the word closed by a lower half carries the upper half written just before it
    a_r7_lo_joins_staged: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == ACC_LO && $past(wr_en && kind == ACC_HI))
        |-> word[DW-1:HW] == $past(wdata[HW-1:0]));

endmodule

// File: rtl/hwb_rd_mux.sv
// Read multiplexer.
// Puts the selected half (or the whole word) on the host lanes. An upper-half
// read captures the source word so the matching lower-half read stays coherent.
// Assumes: the source is valid in the cycle of the read.
module hwb_rd_mux
    import hwb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  acc_kind_t     kind,
    input  logic [DW-1:0] src,
    output logic [DW-1:0] rdata
);

    localparam int HW = DW / 2;

    logic [HW-1:0] hold_q;
    logic          hold_v;

    // Capture: an upper-half read stores the lower half of the source; a lower-half read consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            hold_v <= 1'b0;
        end else if (rd_en && kind == ACC_HI) begin
            hold_q <= src[HW-1:0];
            hold_v <= 1'b1;
        end else if (rd_en && kind == ACC_LO) begin
            hold_v <= 1'b0;
        end
    end

    // Lane steering: zero when idle, upper lanes idle on a 16-bit bus.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (kind)
                ACC_FULL: rdata = src;
                ACC_HI:   rdata = {{HW{1'b0}}, src[DW-1:HW]};
                default:  rdata = {{HW{1'b0}}, (hold_v ? hold_q : src[HW-1:0])};
            endcase
        end
    end

    // R5: half-width reads never drive the upper lanes
    a_r5_upper_lanes_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != ACC_FULL) |-> rdata[DW-1:HW] == '0);

    // R6: a lower-half read right after an upper-half read returns the captured word
    a_r6_capture_used: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && kind == ACC_LO && $past(rd_en && kind == ACC_HI))
        |-> rdata[HW-1:0] == $past(src[HW-1:0]));

endmodule

// File: rtl/host_word_bridge.sv
// Host half-word swap bridge (top).
// Adapts a 32-bit internal data path to a 32-bit or 16-bit host bus. It holds
// the half-swap register and registers the write pulse to the target.
// Assumes: chip select is decoded upstream; bus16 is static after reset.
module host_word_bridge
    import hwb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus16,
    input  logic          hst_cs,
    input  logic          hst_rd,
    input  logic          hst_wr,
    input  logic          hst_a1,
    input  logic          hst_swap_sel,
    input  logic [DW-1:0] hst_wdata,
    output logic [DW-1:0] hst_rdata,
    input  logic [DW-1:0] tgt_rdata,
    output logic          tgt_we,
    output logic [DW-1:0] tgt_wdata
);

    logic [DW-1:0] swap_q;
    logic          all_ones;
    logic          rd_en;
    logic          wr_en;
    acc_kind_t     kind;
    logic          commit;
    logic [DW-1:0] word;
    logic [DW-1:0] rd_src;

    // Access decode: strobes qualified by chip select, half picked by A1 and the mode.
    always_comb begin
        rd_en  = hst_cs && hst_rd;
        wr_en  = hst_cs && hst_wr;
        kind   = classify(bus16, hst_a1, all_ones);
        rd_src = hst_swap_sel ? swap_q : tgt_rdata;
    end

    hwb_swap_reg #(.DW(DW)) u_swap (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (commit && hst_swap_sel),
        .wr_word  (word),
        .value    (swap_q),
        .all_ones (all_ones)
    );

    hwb_wr_asm #(.DW(DW)) u_wasm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .kind   (kind),
        .wdata  (hst_wdata),
        .commit (commit),
        .word   (word)
    );

    hwb_rd_mux #(.DW(DW)) u_rmux (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (rd_en),
        .kind  (kind),
        .src   (rd_src),
        .rdata (hst_rdata)
    );

    // Target port: one-cycle write pulse carrying the assembled word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_we    <= 1'b0;
            tgt_wdata <= '0;
        end else begin
            tgt_we <= commit && !hst_swap_sel;
            if (commit && !hst_swap_sel)
                tgt_wdata <= word;
        end
    end

    // R7: a target pulse is always caused by a completing write outside the swap register
    a_r7_we_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_we |-> $past(hst_cs && hst_wr && !hst_swap_sel && kind != ACC_HI));

    // R8: on a 32-bit bus the committed word is the host word unchanged
    a_r8_full_word_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_we && !bus16) |-> tgt_wdata == $past(hst_wdata));

    // R9: the swap register moves only on writes that select it
    a_r9_swap_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        !(hst_cs && hst_wr && hst_swap_sel) |=> $stable(swap_q));

endmodule

// File: tb/sim_host_word_bridge.sv
module sim_host_word_bridge;

    localparam int  CLK_PERIOD = 10;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus16 = 1'b0;
    logic        hst_cs = 1'b0, hst_rd = 1'b0, hst_wr = 1'b0, hst_a1 = 1'b0, hst_swap_sel = 1'b0;
    logic [31:0] hst_wdata = '0, tgt_rdata = '0;
    logic [31:0] hst_rdata, tgt_wdata;
    logic        tgt_we;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;

    // reference model state
    logic [31:0] m_swap, m_stage, m_hold;
    logic        m_hv;

    always #(CLK_PERIOD/2) clk = ~clk;

    host_word_bridge u0 (
        .clk(clk), .rst_n(rst_n), .bus16(bus16),
        .hst_cs(hst_cs), .hst_rd(hst_rd), .hst_wr(hst_wr), .hst_a1(hst_a1),
        .hst_swap_sel(hst_swap_sel), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .tgt_rdata(tgt_rdata), .tgt_we(tgt_we), .tgt_wdata(tgt_wdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // true when this access moves bytes 3:2 on a 16-bit bus
    function automatic bit upper_half(input bit a1, input logic [31:0] sw);
        return a1 ^ (sw == ONES);
    endfunction

    task automatic do_reset(input bit width16);
        @(negedge clk);
        rst_n = 1'b0; bus16 = width16;
        hst_cs = 0; hst_rd = 0; hst_wr = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_swap = '0; m_stage = '0; m_hold = '0; m_hv = 1'b0;
        #1;
        check("R10 tgt_we after reset", {31'b0, tgt_we}, 32'h0);
    endtask

    // One host access cycle with full expected-value computation.
    task automatic op(input bit cs, input bit rd, input bit wr, input bit sel, input bit a1,
                      input logic [31:0] td, input logic [31:0] wd);
        logic [31:0] src, exp_rd, word, n_swap, n_stage, n_hold;
        logic        n_hv, exp_we;
        string       tag;
        @(negedge clk);
        hst_cs = cs; hst_rd = rd; hst_wr = wr; hst_swap_sel = sel; hst_a1 = a1;
        tgt_rdata = td; hst_wdata = wd;
        n_swap = m_swap; n_stage = m_stage; n_hold = m_hold; n_hv = m_hv;
        exp_rd = '0; tag = "R2 idle read bus";
        if (cs && rd) begin
            src = sel ? m_swap : td;
            if (!bus16) begin
                exp_rd = src; tag = sel ? "R9 swap readback 32" : "R1 full read";
            end else if (upper_half(a1, m_swap)) begin
                exp_rd = {16'h0, src[31:16]}; n_hold = src; n_hv = 1'b1;
                tag = (m_swap == ONES) ? "R3 upper half" : "R4 upper half";
            end else begin
                exp_rd = {16'h0, (m_hv ? m_hold[15:0] : src[15:0])}; n_hv = 1'b0;
                tag = m_hv ? "R6 captured lower half" :
                      ((m_swap == ONES) ? "R3 lower half" : "R4 lower half");
            end
        end
        #1;
        check(tag, hst_rdata, exp_rd);
        if (bus16) check("R5 upper lanes", {16'h0, hst_rdata[31:16]}, 32'h0);
        exp_we = 1'b0; word = '0;
        if (cs && wr) begin
            if (!bus16) word = wd;
            else if (upper_half(a1, m_swap)) n_stage = {16'h0, wd[15:0]};
            else word = {m_stage[15:0], wd[15:0]};
            if (!bus16 || !upper_half(a1, m_swap)) begin
                if (sel) n_swap = word;
                else exp_we = 1'b1;
            end
        end
        @(posedge clk); #1;
        check(sel ? "R9 no target pulse" : (bus16 ? "R7 pulse" : "R8 pulse"),
              {31'b0, tgt_we}, {31'b0, exp_we});
        if (exp_we) check(bus16 ? "R7 assembled word" : "R8 full word", tgt_wdata, word);
        m_swap = n_swap; m_stage = n_stage; m_hold = n_hold; m_hv = n_hv;
        hst_cs = 0; hst_rd = 0; hst_wr = 0;
    endtask

    task automatic random_ops(input int n);
        for (int i = 0; i < n; i++) begin
            logic [31:0] w;
            w = $urandom();
            // bias swap writes toward the all-ones value so both modes occur
            if ($urandom_range(0, 3) == 0) w = ($urandom_range(0, 1) != 0) ? ONES : ONES - 1;
            op($urandom_range(0, 7) != 0, $urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0,
               $urandom_range(0, 3) == 0, $urandom_range(0, 1) != 0, $urandom(), w);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        // 32-bit bus
        do_reset(1'b0);
        op(1, 1, 0, 1, 0, 32'h0, 32'h0);                  // R10 swap reads zero
        op(1, 1, 0, 0, 0, 32'hA1B2_C3D4, 32'h0);          // R1
        op(0, 1, 0, 0, 0, 32'h1111_2222, 32'h0);          // R2 no chip select
        op(1, 0, 1, 0, 1, 32'h0, 32'hDEAD_BEEF);          // R8
        op(1, 0, 1, 1, 0, 32'h0, ONES);                   // R9 write all ones
        op(1, 1, 0, 1, 0, 32'h0, 32'h0);                  // R9 readback
        random_ops(400);
        // 16-bit bus, reset mode: A1=1 is upper
        do_reset(1'b1);
        op(1, 1, 0, 0, 1, 32'h1234_5678, 32'h0);          // R4 upper, capture
        op(1, 1, 0, 0, 0, 32'h9999_AAAA, 32'h0);          // R6 captured lower
        op(1, 1, 0, 0, 0, 32'hBBBB_CCCC, 32'h0);          // R4 live lower
        op(1, 0, 1, 0, 1, 32'h0, 32'hFFFF_0102);          // R7 stage, R5 upper ignored
        op(1, 0, 1, 0, 0, 32'h0, 32'hEEEE_0304);          // R7 commit 0102_0304
        op(1, 0, 1, 1, 1, 32'h0, 32'h0000_FFFF);          // R9 stage
        op(1, 1, 1, 1, 0, 32'h0, 32'h0000_FFFF);          // R9 commit while reading old mode
        op(1, 1, 0, 0, 0, 32'h5566_7788, 32'h0);          // R3 A1=0 now upper
        op(1, 1, 0, 0, 1, 32'h0, 32'h0);                  // R6 captured lower
        op(1, 0, 1, 1, 0, 32'h0, 32'h0000_FFFF);          // R9 stage (mode all ones)
        op(1, 0, 1, 1, 1, 32'h0, 32'h0000_FFFE);          // R9 commit all-ones minus one
        op(1, 1, 0, 0, 1, 32'h0A0B_0C0D, 32'h0);          // R4 exact match needed
        random_ops(1200);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule